// File: doc/BRIEF.md
# Priority Pin Crossbar Allocator

This block routes a set of digital peripheral functions onto a row of general-purpose port pins. Each function (a "resource") has a fixed rank: index 0 ranks highest and the last index ranks lowest. Software supplies three things: which resources are switched on, how many pins each one needs, and which pins are reserved for other uses and must be left alone. The block then walks the resources from highest rank to lowest. Each enabled resource gets the lowest pins that are neither reserved nor already handed out. Switching a resource off frees its pins, so every resource of lower rank slides down to fill the gap.

The placement is computed combinationally. It is loaded into an output register on the clock edge that follows any change of the configuration, and it holds while the configuration stays the same. For each pin, the block reports which resource and which of that resource's pin slots drives it, and whether the pin is in use at all. For each resource, it reports its first pin and whether it was placed or ran out of room. A pad select stage uses the registered placement to pick, for each pin, either the output bit of the owning resource slot or the pin's own port latch bit.

The interface carries no streamed data, so it has no valid/ready handshake and nothing to apply back-pressure to. Every pin is a plain level: configuration inputs are sampled on each rising clock edge, and the data paths through the pad select are combinational.

Top module: `pin_xbar`

## Requirements
- R1: Enabled resources are placed in rank order, index 0 first. Each one takes the lowest-numbered pins that are not reserved and not already given to a higher-ranked resource.
- R2: A pin whose `pin_skip` bit is 1 is never used (`pin_used` is 0) and is stepped over during placement.
- R3: If fewer unreserved free pins remain than a resource needs, that resource's `res_ovf` is 1, `res_placed` is 0, it owns no pin and `res_base` is 0. Lower-ranked resources are still placed on the pins that remain.
- R4: A resource whose `res_en` bit is 0 owns no pin, and its `res_ovf`, `res_placed` and `res_base` are all 0. Lower-ranked resources take the pins it would have used.
- R5: A resource needing 2 pins gets slot 0 on the first free pin and slot 1 on the next free unreserved pin, which need not be adjacent. `pin_slot` reports 0 or 1 for each pin, and `res_base` gives the slot-0 pin.
- R6: The need field of resource r is `res_need[2r+1:2r]`. A value of 0 means the resource takes no pin and sets no flag, even when enabled. Values above the maximum of 2 count as 2.
- R7: A pin that is not in use reports `pin_used` = 0, `pin_res` = 0 and `pin_slot` = 0, and drives `pad_out` from its `port_latch` bit.
- R8: A pin in use drives `pad_out` from `res_dout[r*2 + s]`, where r is its resource and s is its slot. This path is combinational from `res_dout`.
- R9: The placement outputs reflect the configuration (`res_en`, `res_need`, `pin_skip`) sampled at the previous rising edge. They do not move between edges and hold while the configuration is unchanged.
- R10: While `rst_n` is low, all placement outputs are 0 and every `pad_out` bit equals its `port_latch` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_en | input | NR (8) | Enable per resource, bit 0 ranks highest |
| res_need | input | NR*CW (16) | Pins needed per resource, 2 bits each |
| pin_skip | input | NP (16) | Reserved-pin mask, 1 = never use |
| port_latch | input | NP (16) | Port latch value driven on unused pins |
| res_dout | input | NR*MP (16) | Output bit per resource slot, index r*MP+s |
| pin_res | output | NP*RIW (48) | Owning resource per pin, 3 bits each |
| pin_slot | output | NP*SW (16) | Slot of the owning resource per pin |
| pin_used | output | NP (16) | Pin is routed to a resource |
| res_base | output | NR*PIW (32) | Slot-0 pin per resource, 4 bits each |
| res_ovf | output | NR (8) | Resource could not be fitted |
| res_placed | output | NR (8) | Resource owns its pins |
| pad_out | output | NP (16) | Selected pad output value per pin |

## Verification
The assertions assume that all configuration inputs are launched from the same clock domain and settle before each rising edge. Under that assumption, a value captured with `$past` is exactly what the placement register loaded. They also assume the need field may hold the out-of-range value 3, so the count property clamps before it compares. The bench changes every input only on falling edges. It draws need values mostly from 0 to 2, with an occasional 3, and it repeats configurations unchanged so that the hold behaviour is exercised within those rules.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int unsigned DEF_PINS  = 16;
  localparam int unsigned DEF_RES   = 8;
  localparam int unsigned DEF_MAXPR = 2;

  // Index width that stays at least one bit wide for tiny counts.
  function automatic int unsigned idx_w(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/xbar_cfg_watch.sv
module xbar_cfg_watch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cfg_i,
  output logic         changed_o
);

  logic [W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= cfg_i;
  end

  assign changed_o = (cfg_i != shadow_q);

endmodule

// File: rtl/xbar_alloc_core.sv
module xbar_alloc_core #(
  parameter int unsigned NP  = 16,
  parameter int unsigned NR  = 8,
  parameter int unsigned MP  = 2,
  parameter int unsigned CW  = xbar_pkg::idx_w(MP + 1),
  parameter int unsigned SW  = xbar_pkg::idx_w(MP),
  parameter int unsigned RIW = xbar_pkg::idx_w(NR),
  parameter int unsigned PIW = xbar_pkg::idx_w(NP)
) (
  input  logic [NR-1:0]     en_i,
  input  logic [NR*CW-1:0]  need_i,
  input  logic [NP-1:0]     skip_i,
  output logic [NP*RIW-1:0] pin_res_o,
  output logic [NP*SW-1:0]  pin_slot_o,
  output logic [NP-1:0]     used_o,
  output logic [NR*PIW-1:0] base_o,
  output logic [NR-1:0]     ovf_o,
  output logic [NR-1:0]     placed_o
);

  int need_v;
  int avail_v;
  int got_v;

  // Greedy walk: rank order outer, pin order inner. Taken pins are used_o.
  always_comb begin
    pin_res_o  = '0;
    pin_slot_o = '0;
    used_o     = '0;
    base_o     = '0;
    ovf_o      = '0;
    placed_o   = '0;
    need_v     = 0;
    avail_v    = 0;
    got_v      = 0;
    for (int r = 0; r < NR; r++) begin
      need_v = int'(need_i[r*CW +: CW]);
      if (need_v > int'(MP)) need_v = int'(MP);
      if (en_i[r] && need_v != 0) begin
        avail_v = 0;
        for (int q = 0; q < NP; q++) begin
          if (!skip_i[q] && !used_o[q]) avail_v = avail_v + 1;
        end
        if (avail_v < need_v) begin
          ovf_o[r] = 1'b1;
        end else begin
          got_v = 0;
          for (int q = 0; q < NP; q++) begin
            if (!skip_i[q] && !used_o[q] && got_v < need_v) begin
              used_o[q]                 = 1'b1;
              pin_res_o[q*RIW +: RIW]   = RIW'(r);
              pin_slot_o[q*SW +: SW]    = SW'(got_v);
              if (got_v == 0) base_o[r*PIW +: PIW] = PIW'(q);
              got_v = got_v + 1;
            end
          end
          placed_o[r] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/xbar_pad_mux.sv
module xbar_pad_mux #(
  parameter int unsigned NP  = 16,
  parameter int unsigned NR  = 8,
  parameter int unsigned MP  = 2,
  parameter int unsigned SW  = xbar_pkg::idx_w(MP),
  parameter int unsigned RIW = xbar_pkg::idx_w(NR),
  localparam int unsigned NS = NR * MP,
  localparam int unsigned DW = xbar_pkg::idx_w(NS)
) (
  input  logic [NP*RIW-1:0] pin_res_i,
  input  logic [NP*SW-1:0]  pin_slot_i,
  input  logic [NP-1:0]     used_i,
  input  logic [NP-1:0]     latch_i,
  input  logic [NS-1:0]     dout_i,
  output logic [NP-1:0]     pad_o
);

  for (genvar p = 0; p < NP; p++) begin : g_pin
    logic [DW-1:0] sel;
    assign sel = DW'(int'(pin_res_i[p*RIW +: RIW]) * int'(MP)
                     + int'(pin_slot_i[p*SW +: SW]));
    assign pad_o[p] = used_i[p] ? dout_i[sel] : latch_i[p];
  end

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar #(
  parameter int unsigned NP  = xbar_pkg::DEF_PINS,
  parameter int unsigned NR  = xbar_pkg::DEF_RES,
  parameter int unsigned MP  = xbar_pkg::DEF_MAXPR,
  localparam int unsigned CW  = xbar_pkg::idx_w(MP + 1),
  localparam int unsigned SW  = xbar_pkg::idx_w(MP),
  localparam int unsigned RIW = xbar_pkg::idx_w(NR),
  localparam int unsigned PIW = xbar_pkg::idx_w(NP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NR-1:0]     res_en,
  input  logic [NR*CW-1:0]  res_need,
  input  logic [NP-1:0]     pin_skip,
  input  logic [NP-1:0]     port_latch,
  input  logic [NR*MP-1:0]  res_dout,
  output logic [NP*RIW-1:0] pin_res,
  output logic [NP*SW-1:0]  pin_slot,
  output logic [NP-1:0]     pin_used,
  output logic [NR*PIW-1:0] res_base,
  output logic [NR-1:0]     res_ovf,
  output logic [NR-1:0]     res_placed,
  output logic [NP-1:0]     pad_out
);

  localparam int unsigned CFGW = NR + NR*CW + NP;

  logic              cfg_changed;
  logic [NP*RIW-1:0] c_pin_res;
  logic [NP*SW-1:0]  c_pin_slot;
  logic [NP-1:0]     c_used;
  logic [NR*PIW-1:0] c_base;
  logic [NR-1:0]     c_ovf;
  logic [NR-1:0]     c_placed;

  xbar_cfg_watch #(.W(CFGW)) u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_i     ({res_en, res_need, pin_skip}),
    .changed_o (cfg_changed)
  );

  xbar_alloc_core #(.NP(NP), .NR(NR), .MP(MP)) u_core (
    .en_i       (res_en),
    .need_i     (res_need),
    .skip_i     (pin_skip),
    .pin_res_o  (c_pin_res),
    .pin_slot_o (c_pin_slot),
    .used_o     (c_used),
    .base_o     (c_base),
    .ovf_o      (c_ovf),
    .placed_o   (c_placed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_res    <= '0;
      pin_slot   <= '0;
      pin_used   <= '0;
      res_base   <= '0;
      res_ovf    <= '0;
      res_placed <= '0;
    end else if (cfg_changed) begin
      pin_res    <= c_pin_res;
      pin_slot   <= c_pin_slot;
      pin_used   <= c_used;
      res_base   <= c_base;
      res_ovf    <= c_ovf;
      res_placed <= c_placed;
    end
  end

  xbar_pad_mux #(.NP(NP), .NR(NR), .MP(MP)) u_pads (
    .pin_res_i  (pin_res),
    .pin_slot_i (pin_slot),
    .used_i     (pin_used),
    .latch_i    (port_latch),
    .dout_i     (res_dout),
    .pad_o      (pad_out)
  );

endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
  parameter int unsigned NP  = 16,
  parameter int unsigned NR  = 8,
  parameter int unsigned MP  = 2,
  localparam int unsigned CW  = xbar_pkg::idx_w(MP + 1),
  localparam int unsigned SW  = xbar_pkg::idx_w(MP),
  localparam int unsigned RIW = xbar_pkg::idx_w(NR),
  localparam int unsigned PIW = xbar_pkg::idx_w(NP)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NR-1:0]     res_en,
  input logic [NR*CW-1:0]  res_need,
  input logic [NP-1:0]     pin_skip,
  input logic [NP*RIW-1:0] pin_res,
  input logic [NP*SW-1:0]  pin_slot,
  input logic [NP-1:0]     pin_used,
  input logic [NR*PIW-1:0] res_base,
  input logic [NR-1:0]     res_ovf,
  input logic [NR-1:0]     res_placed
);

  localparam int unsigned CFGW = NR + NR*CW + NP;

  logic            seen1;
  logic            seen2;
  logic [CFGW-1:0] cfg;

  assign cfg = {res_en, res_need, pin_skip};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else begin
      seen1 <= 1'b1;
      seen2 <= seen1;
    end
  end

  function automatic int clampn(logic [CW-1:0] v);
    return (int'(v) > int'(MP)) ? int'(MP) : int'(v);
  endfunction

  assert_skip_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen1 |-> ((pin_used & $past(pin_skip)) == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen2 && ($past(cfg) == $past(cfg, 2))) |->
      ($stable(pin_used) && $stable(pin_res) && $stable(pin_slot)
       && $stable(res_base) && $stable(res_ovf) && $stable(res_placed)));

  for (genvar r = 0; r < NR; r++) begin : g_res
    logic [NP-1:0] own;
    always_comb begin
      for (int q = 0; q < NP; q++)
        own[q] = pin_used[q] && (pin_res[q*RIW +: RIW] == RIW'(r));
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      res_ovf[r] |-> ((own == '0) && !res_placed[r]));

    assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen1 && !$past(res_en[r])) |->
        ((own == '0) && !res_ovf[r] && !res_placed[r]));

    assert_base_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_placed[r] |->
        (own[res_base[r*PIW +: PIW]]
         && (pin_slot[res_base[r*PIW +: PIW]*SW +: SW] == '0)));

    assert_pin_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen1 && res_placed[r]) |->
        ($countones(own) == clampn($past(res_need[r*CW +: CW]))));
  end

endmodule

bind pin_xbar xbar_chk #(.NP(NP), .NR(NR), .MP(MP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_en     (res_en),
  .res_need   (res_need),
  .pin_skip   (pin_skip),
  .pin_res    (pin_res),
  .pin_slot   (pin_slot),
  .pin_used   (pin_used),
  .res_base   (res_base),
  .res_ovf    (res_ovf),
  .res_placed (res_placed)
);

// File: tb/pin_xbar_bench.sv
module pin_xbar_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int NR = 8;
  localparam int MP = 2;
  localparam int CW = 2;
  localparam int SW = 1;
  localparam int RIW = 3;
  localparam int PIW = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NR-1:0]     res_en = '0;
  logic [NR*CW-1:0]  res_need = '0;
  logic [NP-1:0]     pin_skip = '0;
  logic [NP-1:0]     port_latch = '0;
  logic [NR*MP-1:0]  res_dout = '0;
  logic [NP*RIW-1:0] pin_res;
  logic [NP*SW-1:0]  pin_slot;
  logic [NP-1:0]     pin_used;
  logic [NR*PIW-1:0] res_base;
  logic [NR-1:0]     res_ovf;
  logic [NR-1:0]     res_placed;
  logic [NP-1:0]     pad_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_xbar #(.NP(NP), .NR(NR), .MP(MP)) u_pin_xbar (
    .clk(clk), .rst_n(rst_n), .res_en(res_en), .res_need(res_need),
    .pin_skip(pin_skip), .port_latch(port_latch), .res_dout(res_dout),
    .pin_res(pin_res), .pin_slot(pin_slot), .pin_used(pin_used),
    .res_base(res_base), .res_ovf(res_ovf), .res_placed(res_placed),
    .pad_out(pad_out)
  );

  int n_chk = 0;
  int n_bad = 0;

  bit e_used[NP];
  int e_res[NP];
  int e_slot[NP];
  int e_base[NR];
  bit e_ovf[NR];
  bit e_placed[NR];

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int need_of(int r);
    int v = int'(res_need[r*CW +: CW]);
    return (v > MP) ? MP : v;
  endfunction

  // Reference: list the usable pins, then hand them out front to back.
  task automatic model();
    int list[NP];
    int nfree = 0;
    int ptr = 0;
    for (int q = 0; q < NP; q++) begin
      e_used[q] = 0; e_res[q] = 0; e_slot[q] = 0;
      if (!pin_skip[q]) begin list[nfree] = q; nfree++; end
    end
    for (int r = 0; r < NR; r++) begin
      int n = need_of(r);
      e_base[r] = 0; e_ovf[r] = 0; e_placed[r] = 0;
      if (res_en[r] && n > 0) begin
        if (ptr + n > nfree) e_ovf[r] = 1;
        else begin
          for (int k = 0; k < n; k++) begin
            e_used[list[ptr+k]] = 1;
            e_res[list[ptr+k]]  = r;
            e_slot[list[ptr+k]] = k;
          end
          e_base[r] = list[ptr];
          e_placed[r] = 1;
          ptr += n;
        end
      end
    end
  endtask

  task automatic check_all();
    for (int q = 0; q < NP; q++) begin
      string tg = pin_skip[q] ? "R2" : (e_used[q] ? "R1" : "R7");
      chk(tg, $sformatf("pin%0d used", q), int'(pin_used[q]), int'(e_used[q]));
      chk(tg, $sformatf("pin%0d res", q), int'(pin_res[q*RIW +: RIW]), e_res[q]);
      chk(e_slot[q] != 0 ? "R5" : tg, $sformatf("pin%0d slot", q),
          int'(pin_slot[q*SW +: SW]), e_slot[q]);
      if (e_used[q])
        chk("R8", $sformatf("pin%0d pad", q), int'(pad_out[q]),
            int'(res_dout[e_res[q]*MP + e_slot[q]]));
      else
        chk("R7", $sformatf("pin%0d pad", q), int'(pad_out[q]), int'(port_latch[q]));
    end
    for (int r = 0; r < NR; r++) begin
      string tg = e_ovf[r] ? "R3" : (!res_en[r] ? "R4" :
                  (need_of(r) == 0 ? "R6" : (need_of(r) == 2 ? "R5" : "R1")));
      chk(tg, $sformatf("res%0d ovf", r), int'(res_ovf[r]), int'(e_ovf[r]));
      chk(tg, $sformatf("res%0d placed", r), int'(res_placed[r]), int'(e_placed[r]));
      chk(tg, $sformatf("res%0d base", r), int'(res_base[r*PIW +: PIW]), e_base[r]);
    end
  endtask

  // Drive on a falling edge; outputs must not move before the next rising edge.
  task automatic apply(logic [NR-1:0] en, logic [NR*CW-1:0] nd, logic [NP-1:0] sk);
    logic [NP-1:0] old_used;
    logic [NR-1:0] old_ovf;
    @(negedge clk);
    old_used = pin_used;
    old_ovf  = res_ovf;
    res_en = en; res_need = nd; pin_skip = sk;
    port_latch = NP'($urandom);
    res_dout   = (NR*MP)'($urandom);
    #1;
    chk("R9", "used before edge", int'(pin_used), int'(old_used));
    chk("R9", "ovf before edge", int'(res_ovf), int'(old_ovf));
    model();
    @(negedge clk);
    check_all();
  endtask

  function automatic logic [NR*CW-1:0] all_need(int v);
    logic [NR*CW-1:0] x = '0;
    for (int r = 0; r < NR; r++) x[r*CW +: CW] = CW'(v);
    return x;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NR*CW-1:0] nd;
    void'($urandom(32'd20240611));
    // R10: reset holds everything clear even with live inputs.
    res_en = '1; res_need = all_need(1); port_latch = 16'hA5C3;
    repeat (3) @(negedge clk);
    chk("R10", "reset used", int'(pin_used), 0);
    chk("R10", "reset ovf", int'(res_ovf), 0);
    chk("R10", "reset placed", int'(res_placed), 0);
    chk("R10", "reset res", int'(pin_res), 0);
    chk("R10", "reset base", int'(res_base), 0);
    chk("R10", "reset pad", int'(pad_out), int'(port_latch));
    rst_n = 1'b1;
    res_en = '0; res_need = '0;
    @(negedge clk);

    // R1: one pin each, no reservations -> resource r on pin r.
    apply('1, all_need(1), '0);
    // R2: reserve even pins.
    apply('1, all_need(1), 16'h5555);
    // R5: every resource takes two, all pins used.
    apply('1, all_need(2), '0);
    // R5: a reserved pin splits a pair.
    apply('1, all_need(2), 16'h0002);
    // R3: only three usable pins; resource 1 (two) fails, resource 2 (one) fits.
    nd = '0; nd[1:0] = 2'd2; nd[3:2] = 2'd2; nd[5:4] = 2'd1;
    apply(8'h07, nd, 16'hFFF8 & ~16'h0000 | 16'h1FF8);
    // R4: drop the top resource, the rest slide down.
    apply(8'hFE, all_need(1), '0);
    // R6: need 0 while enabled, and need 3 clamps to 2.
    nd = all_need(1); nd[1:0] = 2'd0; nd[5:4] = 2'd3;
    apply('1, nd, '0);
    // R9: same configuration again, then idle cycles; outputs hold.
    apply(res_en, res_need, pin_skip);
    repeat (2) @(negedge clk);
    check_all();

    for (int i = 0; i < 300; i++) begin
      logic [NR*CW-1:0] rn = '0;
      for (int r = 0; r < NR; r++)
        rn[r*CW +: CW] = ($urandom_range(0, 9) == 0) ? 2'd3 : CW'($urandom_range(0, 2));
      if ($urandom_range(0, 7) == 0) apply(res_en, res_need, pin_skip);
      else apply(NR'($urandom), rn, NP'($urandom & $urandom));
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule